// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is a bank of system control registers on a single-cycle 32-bit register port. The port has an address, a write enable, write data and a combinational read data path. It holds two oscillator setting words that only accept writes after a 16-bit unlock key has been loaded into a key register. It also holds a control word whose bit 2 hides the boot flash alias at address zero, and SDRAM and init configuration words. The SDRAM word carries a size code derived from a memory-size parameter.

The bank also contains a free-running 32-bit reference counter, which advances at a fractional rate of REF_HZ per CLK_HZ clock cycles (24 MHz on a 50 MHz clock by default). There are two flag words written through set and clear addresses. One of them survives a warm reset. A one-bit local interrupt source is raised and dropped by software and routed to an IRQ and an FIQ output through separate enable masks.

`rst_ni` is the asynchronous power-on reset. `warm_rst_ni` is a synchronous warm reset that restores every register except the persistent flag word.

Top module: `cm_ctrl_bank`

## Requirements
- R1: After power-on reset the registers read as follows.
  - The oscillator word is 0x01000048 and the auxiliary oscillator word is 0x0007FEFF.
  - The init word is 0x00000112.
  - The control, key, flag, persistent flag, enable and counter registers are zero.
  - `flash_alias_off_o`, `irq_o` and `fiq_o` are low.
- R2: A write to the oscillator word (0x00) or the auxiliary oscillator word (0x0C) takes effect only while the key register holds 0xA05F. Otherwise the stored value is unchanged.
- R3: A write to the key register (0x08) keeps only the low 16 bits of the data. A read returns the stored value, with bit 16 also set when the value equals 0xA05F.
- R4: In the control word (0x04) only bits 0 and 2 are writable, and the other bits read as zero. `flash_alias_off_o` follows bit 2.
- R5: The SDRAM word (0x10) resets to 0x00011122 ORed with a size code taken from MEM_MB:
  - 0x10 when MEM_MB is at least 256;
  - 0x0C when it is at least 128;
  - 0x08 when it is at least 64;
  - 0x04 when it is at least 32;
  - 0 otherwise.
  The SDRAM word and the init word (0x14) are fully writable.
- R6: The counter (0x28) starts at zero after reset and wraps freely. Over any window of N clock cycles it advances by exactly N*REF_HZ/CLK_HZ when that quotient is whole. It is read-only.
- R7: The flag word reads at 0x30 and 0x34. A write to 0x30 ORs the data in, and a write to 0x34 clears the bits that are one in the data. The persistent flag word does the same at 0x38 (set) and 0x3C (clear).
- R8: A low `warm_rst_ni` at a clock edge restores every register to its R1/R5 value, and it takes priority over writes. The exception is the persistent flag word, which keeps its value and still accepts a set or clear write in that same cycle.
- R9: The interrupt level is one bit. Writing a 1 in data bit 0 to 0x50 sets it, and writing a 1 in data bit 0 to 0x54 clears it. Other data bits have no effect. 0x44 and 0x64 read the level; 0x50 and 0x54 read it too.
- R10: The IRQ enable word is set through 0x48 (which also reads it) and cleared through 0x4C. The FIQ enable word is set through 0x68 and cleared through 0x6C.
  - `irq_o` is the level ANDed with IRQ enable bit 0, and `fiq_o` is the level ANDed with FIQ enable bit 0.
  - 0x40 reads the level ANDed with the IRQ enable word, and 0x60 reads the level ANDed with the FIQ enable word.
- R11: Addresses are byte offsets decoded on bits [7:2]. A read of any offset not listed above returns zero, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_ni | input | 1 | Synchronous warm reset, active low |
| addr_i | input | ADDR_W | Byte address of the register access |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| flash_alias_off_o | output | 1 | High when the boot flash alias at zero is disabled |
| irq_o | output | 1 | Local interrupt request, IRQ path |
| fiq_o | output | 1 | Local interrupt request, FIQ path |

## Verification
Warm reset and a register write can land on the same clock edge, and the block must then split its behaviour. The write to the persistent flags lands, while a write to the ordinary flags is discarded. The bench drives a low `warm_rst_ni` together with a persistent-flag set write, and in a second cycle together with an ordinary flag set write. It then reads back both flag words, the control word, the key and the oscillator word and compares them with the values R8 predicts. The counter is sampled across fixed windows that include a write to its own address, so the count and the ignored write are judged in the same window.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int unsigned DW = 32;

  // word indices (byte offset >> 2)
  localparam logic [31:0] A_OSC   = 32'h00;
  localparam logic [31:0] A_CTRL  = 32'h01;
  localparam logic [31:0] A_KEY   = 32'h02;
  localparam logic [31:0] A_AUX   = 32'h03;
  localparam logic [31:0] A_SDRAM = 32'h04;
  localparam logic [31:0] A_INIT  = 32'h05;
  localparam logic [31:0] A_REF   = 32'h0A;
  localparam logic [31:0] A_FSET  = 32'h0C;
  localparam logic [31:0] A_FCLR  = 32'h0D;
  localparam logic [31:0] A_NSET  = 32'h0E;
  localparam logic [31:0] A_NCLR  = 32'h0F;
  localparam logic [31:0] A_ISTAT = 32'h10;
  localparam logic [31:0] A_IRAW  = 32'h11;
  localparam logic [31:0] A_IENS  = 32'h12;
  localparam logic [31:0] A_IENC  = 32'h13;
  localparam logic [31:0] A_SSET  = 32'h14;
  localparam logic [31:0] A_SCLR  = 32'h15;
  localparam logic [31:0] A_FSTAT = 32'h18;
  localparam logic [31:0] A_FRAW  = 32'h19;
  localparam logic [31:0] A_FENS  = 32'h1A;
  localparam logic [31:0] A_FENC  = 32'h1B;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] CTRL_WMASK = 32'h0000_0005;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;

  function automatic logic [31:0] sdram_size_code(input int unsigned mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction
endpackage

// File: rtl/cm_setclr.sv
module cm_setclr #(
  parameter int unsigned W        = 32,
  parameter logic [W-1:0] RST     = '0,
  parameter bit           WARM_CLR = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         warm_rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  logic warm_hit;
  assign warm_hit = WARM_CLR && !warm_rst_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= RST;
    else if (warm_hit) q_o <= RST;
    else if (set_i)    q_o <= q_o | data_i;
    else if (clr_i)    q_o <= q_o & ~data_i;
  end

  // R7
  set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !warm_hit) |=> ((q_o & $past(data_i)) == $past(data_i)));
  // R7
  clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i && !warm_hit) |=> ((q_o & $past(data_i)) == '0));
endmodule

// File: rtl/cm_refcnt.sv
module cm_refcnt #(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned REF_HZ = 24_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warm_rst_ni,
  output logic [31:0] cnt_o
);
  localparam int unsigned AW = $clog2(CLK_HZ + REF_HZ) + 1;
  localparam logic [AW-1:0] CLK_L = AW'(CLK_HZ);
  localparam logic [AW-1:0] REF_L = AW'(REF_HZ);

  logic [AW-1:0] acc_q, sum;
  logic          wrap;
  assign sum  = acc_q + REF_L;
  assign wrap = sum >= CLK_L;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_o <= '0;
    end else if (!warm_rst_ni) begin
      acc_q <= '0;
      cnt_o <= '0;
    end else begin
      acc_q <= wrap ? sum - CLK_L : sum;
      if (wrap) cnt_o <= cnt_o + 32'd1;
    end
  end

  // R6
  acc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q < CLK_L);
  // R6
  refcnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_ni |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 32'd1));
endmodule

// File: rtl/cm_lint.sv
module cm_lint (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warm_rst_ni,
  input  logic        sset_i,
  input  logic        sclr_i,
  input  logic        iens_i,
  input  logic        ienc_i,
  input  logic        fens_i,
  input  logic        fenc_i,
  input  logic [31:0] data_i,
  output logic        level_o,
  output logic [31:0] irq_en_o,
  output logic [31:0] fiq_en_o,
  output logic        irq_o,
  output logic        fiq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  level_o <= 1'b0;
    else if (!warm_rst_ni)        level_o <= 1'b0;
    else if (sset_i && data_i[0]) level_o <= 1'b1;
    else if (sclr_i && data_i[0]) level_o <= 1'b0;
  end

  cm_setclr #(.W(32), .RST('0), .WARM_CLR(1'b1)) u_irq_en (
    .clk_i, .rst_ni, .warm_rst_ni, .set_i(iens_i), .clr_i(ienc_i),
    .data_i, .q_o(irq_en_o));

  cm_setclr #(.W(32), .RST('0), .WARM_CLR(1'b1)) u_fiq_en (
    .clk_i, .rst_ni, .warm_rst_ni, .set_i(fens_i), .clr_i(fenc_i),
    .data_i, .q_o(fiq_en_o));

  assign irq_o = level_o & irq_en_o[0];
  assign fiq_o = level_o & fiq_en_o[0];

  // R9
  soft_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sset_i && data_i[0] && warm_rst_ni) |=> level_o);
  // R9
  soft_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_ni && !(sset_i && data_i[0]) && !(sclr_i && data_i[0])) |=> $stable(level_o));
endmodule

// File: rtl/cm_ctrl_bank.sv
module cm_ctrl_bank
  import cm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned MEM_MB = 128,
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned REF_HZ = 24_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              flash_alias_off_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);

  logic [31:0] widx;
  logic        unused_lsb;
  assign widx       = 32'(addr_i[ADDR_W-1:2]);
  assign unused_lsb = ^addr_i[1:0];

  logic wr_fset, wr_fclr, wr_nset, wr_nclr;
  logic wr_iens, wr_ienc, wr_fens, wr_fenc, wr_sset, wr_sclr;
  assign wr_fset = we_i && widx == A_FSET;
  assign wr_fclr = we_i && widx == A_FCLR;
  assign wr_nset = we_i && widx == A_NSET;
  assign wr_nclr = we_i && widx == A_NCLR;
  assign wr_iens = we_i && widx == A_IENS;
  assign wr_ienc = we_i && widx == A_IENC;
  assign wr_fens = we_i && widx == A_FENS;
  assign wr_fenc = we_i && widx == A_FENC;
  assign wr_sset = we_i && widx == A_SSET;
  assign wr_sclr = we_i && widx == A_SCLR;

  logic [31:0] osc_q, aux_q, ctrl_q, sdram_q, init_q;
  logic [15:0] key_q;
  logic        unlocked;
  assign unlocked = key_q == UNLOCK_KEY;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || !warm_rst_ni) begin
      osc_q   <= OSC_RST;
      aux_q   <= AUX_RST;
      ctrl_q  <= '0;
      key_q   <= '0;
      sdram_q <= SDRAM_RST;
      init_q  <= INIT_RST;
    end else if (we_i) begin
      case (widx)
        A_OSC:   if (unlocked) osc_q <= wdata_i;
        A_AUX:   if (unlocked) aux_q <= wdata_i;
        A_CTRL:  ctrl_q  <= (ctrl_q & ~CTRL_WMASK) | (wdata_i & CTRL_WMASK);
        A_KEY:   key_q   <= wdata_i[15:0];
        A_SDRAM: sdram_q <= wdata_i;
        A_INIT:  init_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  logic [31:0] flags_q, nvflags_q, refcnt, irq_en, fiq_en;
  logic        level;

  cm_setclr #(.W(32), .RST('0), .WARM_CLR(1'b1)) u_flags (
    .clk_i, .rst_ni, .warm_rst_ni, .set_i(wr_fset), .clr_i(wr_fclr),
    .data_i(wdata_i), .q_o(flags_q));

  // persistent flags: power-on reset only
  cm_setclr #(.W(32), .RST('0), .WARM_CLR(1'b0)) u_nvflags (
    .clk_i, .rst_ni, .warm_rst_ni, .set_i(wr_nset), .clr_i(wr_nclr),
    .data_i(wdata_i), .q_o(nvflags_q));

  cm_refcnt #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ)) u_refcnt (
    .clk_i, .rst_ni, .warm_rst_ni, .cnt_o(refcnt));

  cm_lint u_lint (
    .clk_i, .rst_ni, .warm_rst_ni,
    .sset_i(wr_sset), .sclr_i(wr_sclr), .iens_i(wr_iens), .ienc_i(wr_ienc),
    .fens_i(wr_fens), .fenc_i(wr_fenc), .data_i(wdata_i),
    .level_o(level), .irq_en_o(irq_en), .fiq_en_o(fiq_en),
    .irq_o(irq_o), .fiq_o(fiq_o));

  assign flash_alias_off_o = ctrl_q[2];

  always_comb begin
    case (widx)
      A_OSC:   rdata_o = osc_q;
      A_CTRL:  rdata_o = ctrl_q;
      A_KEY:   rdata_o = {15'b0, unlocked, key_q};
      A_AUX:   rdata_o = aux_q;
      A_SDRAM: rdata_o = sdram_q;
      A_INIT:  rdata_o = init_q;
      A_REF:   rdata_o = refcnt;
      A_FSET, A_FCLR: rdata_o = flags_q;
      A_NSET, A_NCLR: rdata_o = nvflags_q;
      A_ISTAT: rdata_o = {31'b0, level} & irq_en;
      A_IRAW, A_FRAW, A_SSET, A_SCLR: rdata_o = {31'b0, level};
      A_IENS:  rdata_o = irq_en;
      A_FSTAT: rdata_o = {31'b0, level} & fiq_en;
      A_FENS:  rdata_o = fiq_en;
      default: rdata_o = '0;
    endcase
  end

  // R2
  osc_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && warm_rst_ni && !unlocked && (widx == A_OSC || widx == A_AUX))
      |=> ($stable(osc_q) && $stable(aux_q)));
  // R4
  ctrl_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (widx == A_CTRL) |-> ((rdata_o & ~CTRL_WMASK) == '0 && rdata_o[2] == flash_alias_off_o));
  // R8
  nv_warm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!warm_rst_ni && !wr_nset && !wr_nclr) |=> $stable(nvflags_q));
  // R3
  key_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && warm_rst_ni && widx == A_KEY && wdata_i[15:0] == UNLOCK_KEY) |=> unlocked);
endmodule

// File: tb/tb_cm_ctrl_bank.sv
module tb_cm_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        warm_rst_ni = 1'b1;
  logic [7:0]  addr = 8'h28;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        alias_off, irq, fiq;
  logic [31:0] rd16, rd32, rd64, rd256;
  logic        x16a, x16b, x16c, x32a, x32b, x32c, x64a, x64b, x64c, x256a, x256b, x256c;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cm_ctrl_bank dut (.clk_i(clk), .rst_ni, .warm_rst_ni, .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .flash_alias_off_o(alias_off), .irq_o(irq), .fiq_o(fiq));
  cm_ctrl_bank #(.MEM_MB(16)) dut_m16 (.clk_i(clk), .rst_ni, .warm_rst_ni, .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rd16), .flash_alias_off_o(x16a), .irq_o(x16b), .fiq_o(x16c));
  cm_ctrl_bank #(.MEM_MB(32)) dut_m32 (.clk_i(clk), .rst_ni, .warm_rst_ni, .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rd32), .flash_alias_off_o(x32a), .irq_o(x32b), .fiq_o(x32c));
  cm_ctrl_bank #(.MEM_MB(64)) dut_m64 (.clk_i(clk), .rst_ni, .warm_rst_ni, .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rd64), .flash_alias_off_o(x64a), .irq_o(x64b), .fiq_o(x64c));
  cm_ctrl_bank #(.MEM_MB(256)) dut_m256 (.clk_i(clk), .rst_ni, .warm_rst_ni, .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rd256), .flash_alias_off_o(x256a), .irq_o(x256b), .fiq_o(x256c));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    logic [31:0] v, c0, c1, acc;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1 chk("R6 counter zero at reset", rdata, 32'h0);
    // R1 reset state
    rd_chk("R1 osc", 8'h00, 32'h0100_0048);
    rd_chk("R1 aux", 8'h0C, 32'h0007_FEFF);
    rd_chk("R1 init", 8'h14, 32'h0000_0112);
    rd_chk("R1 ctrl", 8'h04, 32'h0);
    rd_chk("R1 key", 8'h08, 32'h0);
    rd_chk("R1 flags", 8'h30, 32'h0);
    rd_chk("R1 nvflags", 8'h38, 32'h0);
    rd_chk("R1 irq en", 8'h48, 32'h0);
    chk("R1 outputs", {29'b0, alias_off, irq, fiq}, 32'h0);
    // R5 size codes
    addr = 8'h10; #1;
    chk("R5 sdram 128", rdata, 32'h0001_112E);
    chk("R5 sdram 16", rd16, 32'h0001_1122);
    chk("R5 sdram 32", rd32, 32'h0001_1126);
    chk("R5 sdram 64", rd64, 32'h0001_112A);
    chk("R5 sdram 256", rd256, 32'h0001_1132);
    wr(8'h10, 32'hCAFE_F00D); rd_chk("R5 sdram write", 8'h10, 32'hCAFE_F00D);
    wr(8'h14, 32'h1357_9BDF); rd_chk("R5 init write", 8'h14, 32'h1357_9BDF);
    // R2 lock gating
    wr(8'h00, 32'h1234_5678); rd_chk("R2 osc locked", 8'h00, 32'h0100_0048);
    wr(8'h0C, 32'h1234_5678); rd_chk("R2 aux locked", 8'h0C, 32'h0007_FEFF);
    wr(8'h08, 32'hDEAD_A05F); rd_chk("R3 key open read", 8'h08, 32'h0001_A05F);
    wr(8'h00, 32'h1234_5678); rd_chk("R2 osc unlocked", 8'h00, 32'h1234_5678);
    wr(8'h0C, 32'h8765_4321); rd_chk("R2 aux unlocked", 8'h0C, 32'h8765_4321);
    // R3 key sweep: single-bit deviations from the key never open
    for (int i = 0; i < 16; i++) begin
      wr(8'h08, {16'hFFFF, 16'hA05F ^ (16'h1 << i)});
      rd_chk("R3 key sweep", 8'h08, {16'h0, 16'hA05F ^ (16'h1 << i)});
      wr(8'h00, 32'h0000_0000 + i);
      rd_chk("R2 osc sweep locked", 8'h00, 32'h1234_5678);
    end
    // R4 control mask
    for (int i = 0; i < 16; i++) begin
      wr(8'h04, 32'(i));
      rd_chk("R4 ctrl mask", 8'h04, 32'(i) & 32'h5);
      chk("R4 alias out", {31'b0, alias_off}, 32'((i >> 2) & 1));
    end
    wr(8'h04, 32'hFFFF_FFFF); rd_chk("R4 ctrl all ones", 8'h04, 32'h5);
    // R6 counter windows of 50 and 25 cycles -> 24 and 12 counts
    addr = 8'h28;
    @(negedge clk); #1 c0 = rdata;
    repeat (50) @(negedge clk); #1 c1 = rdata;
    chk("R6 50 cycles", c1 - c0, 32'(50 * 24 / 50));
    c0 = c1;
    repeat (25) @(negedge clk); #1 c1 = rdata;
    chk("R6 25 cycles", c1 - c0, 32'(25 * 24 / 50));
    c0 = c1;
    we = 1'b1; wdata = 32'h0;
    @(negedge clk); we = 1'b0;
    repeat (99) @(negedge clk); #1 c1 = rdata;
    chk("R6 read-only 100 cycles", c1 - c0, 32'(100 * 24 / 50));
    // R7 flags sweep
    acc = '0;
    for (int i = 0; i < 32; i++) begin
      wr(8'h30, 32'h1 << i); acc |= 32'h1 << i;
      rd_chk("R7 flag set", 8'h34, acc);
    end
    for (int i = 0; i < 32; i += 2) begin
      wr(8'h34, 32'h1 << i); acc &= ~(32'h1 << i);
      rd_chk("R7 flag clear", 8'h30, acc);
    end
    wr(8'h38, 32'hF0F0_0F0F); wr(8'h38, 32'h0000_1000);
    rd_chk("R7 nv set", 8'h3C, 32'hF0F0_1F0F);
    wr(8'h3C, 32'hF000_000F); rd_chk("R7 nv clear", 8'h38, 32'h00F0_1F00);
    // R9 soft level
    wr(8'h50, 32'hFFFF_FFFE); rd_chk("R9 set bit0 only", 8'h44, 32'h0);
    wr(8'h50, 32'h1); rd_chk("R9 set", 8'h44, 32'h1);
    wr(8'h54, 32'hFFFF_FFFE); rd_chk("R9 clear other bits", 8'h50, 32'h1);
    wr(8'h54, 32'h1); rd_chk("R9 clear", 8'h64, 32'h0);
    // R10 routing sweep over level, irq enable, fiq enable
    for (int k = 0; k < 8; k++) begin
      wr(8'h4C, 32'hFFFF_FFFF); wr(8'h6C, 32'hFFFF_FFFF);
      wr(8'h54, 32'h1);
      if (k[0]) wr(8'h50, 32'h1);
      wr(8'h48, k[1] ? 32'hA000_0001 : 32'hA000_0000);
      wr(8'h68, k[2] ? 32'h0500_0001 : 32'h0500_0000);
      chk("R10 irq_o", {31'b0, irq}, 32'(k[0] & k[1]));
      chk("R10 fiq_o", {31'b0, fiq}, 32'(k[0] & k[2]));
      rd_chk("R10 irq stat", 8'h40, 32'(k[0] & k[1]));
      rd_chk("R10 fiq stat", 8'h60, 32'(k[0] & k[2]));
      rd_chk("R10 irq en", 8'h48, k[1] ? 32'hA000_0001 : 32'hA000_0000);
      rd_chk("R10 fiq en", 8'h68, k[2] ? 32'h0500_0001 : 32'h0500_0000);
    end
    // R11 unmapped
    for (int a = 0; a < 256; a += 4) begin
      if (!(a <= 8'h14 || a == 8'h28 || (a >= 8'h30 && a <= 8'h54) ||
            (a >= 8'h60 && a <= 8'h6C))) begin
        wr(8'(a), 32'hFFFF_FFFF);
        rd_chk("R11 unmapped read", 8'(a), 32'h0);
      end
    end
    rd_chk("R11 osc untouched", 8'h00, 32'h1234_5678);
    rd_chk("R11 ctrl untouched", 8'h04, 32'h5);
    // R8 warm reset with concurrent writes
    wr(8'h08, 32'hA05F);
    wr(8'h30, 32'h0000_00F0);
    @(negedge clk);
    warm_rst_ni = 1'b0; addr = 8'h38; we = 1'b1; wdata = 32'h0000_0001;
    @(negedge clk);
    addr = 8'h30; wdata = 32'h0000_0F00;
    @(negedge clk);
    warm_rst_ni = 1'b1; we = 1'b0;
    rd_chk("R8 nv keeps and takes write", 8'h38, 32'h00F0_1F01);
    rd_chk("R8 flags dropped", 8'h30, 32'h0);
    rd_chk("R8 ctrl restored", 8'h04, 32'h0);
    chk("R8 alias out", {31'b0, alias_off}, 32'h0);
    rd_chk("R8 key restored", 8'h08, 32'h0);
    rd_chk("R8 osc restored", 8'h00, 32'h0100_0048);
    rd_chk("R8 sdram restored", 8'h10, 32'h0001_112E);
    rd_chk("R8 irq en restored", 8'h48, 32'h0);
    rd(8'h28, v);
    chk("R8 counter restarted", 32'(v <= 32'd1), 32'h1);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule